// File: doc/BRIEF.md
# GPIO Input Event Dispatcher

The dispatcher watches a single general-purpose input pin and converts its edges or its level into control requests for the rest of the device. A 4-bit mode input selects what the pin means. An enable input gates the whole function. The pin is first brought into the clock domain, and then rising and falling edges are detected. A decoder turns the active edge or level into either a single-cycle request pulse or a held state.

Some modes act on the whole device. Others act only on the channels set in a channel mask (four channels by default). One mode drives a register-map lock, and a small write guard next to it decides whether a register write is accepted. The bus interfaces, the non-volatile memory and the power, DAC and waveform logic that consume the requests are outside this block.

Top module: `gpin_event_dispatch`

## Requirements
- R1: While `in_en_i` is 0, no pin activity changes any output: pulses stay 0, `clr_o` stays 0, and `reset_o`, `nvm_wr_allow_o` and `map_locked_o` keep their values.
- R2: Mode 4'b0010 is device-wide. A pin falling edge gives a one-cycle `fault_dump_o` pulse. A rising edge or a high level gives nothing.
- R3: Mode 4'b0011 drives current-output power. A falling edge pulses `iout_pdn_o` and a rising edge pulses `iout_pup_o`, on exactly the channels set in `ch_sel_i` (bit n = channel n).
- R4: Mode 4'b0100 does the same as R3 for voltage-output power, on `vout_pdn_o` and `vout_pup_o`.
- R5: Mode 4'b0101 is device-wide. A falling edge gives a one-cycle `protect_o` pulse, and a rising edge gives nothing.
- R6: Mode 4'b0111 is level-sensitive. `clr_o` is 1 for as long as the synchronized pin is 0, and 0 while it is 1.
- R7: Mode 4'b1000 acts per channel. A falling edge pulses `ldac_o` on each channel that is set in both `ch_sel_i` and `sync_en_i`. A rising edge gives nothing.
- R8: Mode 4'b1001 acts per channel. A falling edge pulses `fgen_stop_o` and a rising edge pulses `fgen_start_o`, on the selected channels.
- R9: Mode 4'b1010 acts per channel. A falling edge pulses `margin_lo_o` and a rising edge pulses `margin_hi_o`, on the selected channels.
- R10: Mode 4'b1011 is device-wide. A falling edge sets `reset_o`, which then stays 1 until a rising edge in this mode clears it.
- R11: Mode 4'b1100 holds a level. A falling edge sets `nvm_wr_allow_o` to 1 and a rising edge sets it to 0.
- R12: Mode 4'b1101 holds a level. A rising edge sets `map_locked_o` and a falling edge clears it. `wr_grant_o` equals `wr_req_i` while unlocked. While locked, a write is granted only if it targets the unlock field, or targets the reset field and comes from I2C (`wr_from_i2c_i` = 1).
- R13: Mode codes 0000, 0001, 0110, 1110 and 1111 produce no pulse, keep `clr_o` at 0 and leave every held level unchanged. After reset all outputs are 0, which means unlocked, NVM writes blocked and reset released.
- R14: Each output responds on the third clock edge after the pin changes (two synchronizer stages plus one output register), and each pulse lasts exactly one cycle. A change of `mode_i` or `in_en_i` while the pin is steady creates no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous general-purpose input pin |
| in_en_i | input | 1 | Input function enable |
| mode_i | input | 4 | Event mode code |
| ch_sel_i | input | NCH | Channel select mask for per-channel modes |
| sync_en_i | input | NCH | Per-channel sync enable used by the load-DAC mode |
| wr_req_i | input | 1 | A register write is requested |
| wr_unlock_fld_i | input | 1 | The write targets the unlock field |
| wr_reset_fld_i | input | 1 | The write targets the reset field |
| wr_from_i2c_i | input | 1 | The write arrives over I2C (0 = SPI) |
| wr_grant_o | output | 1 | The write is accepted |
| fault_dump_o | output | 1 | Fault dump request pulse |
| protect_o | output | 1 | Protect request pulse |
| clr_o | output | 1 | Clear level |
| reset_o | output | 1 | Held device reset request |
| nvm_wr_allow_o | output | 1 | NVM programming allowed |
| map_locked_o | output | 1 | Register map locked |
| iout_pdn_o | output | NCH | Current-output power-down pulses |
| iout_pup_o | output | NCH | Current-output power-up pulses |
| vout_pdn_o | output | NCH | Voltage-output power-down pulses |
| vout_pup_o | output | NCH | Voltage-output power-up pulses |
| ldac_o | output | NCH | Load-DAC pulses |
| fgen_stop_o | output | NCH | Function generation stop pulses |
| fgen_start_o | output | NCH | Function generation start pulses |
| margin_lo_o | output | NCH | Margin-low pulses |
| margin_hi_o | output | NCH | Margin-high pulses |

## Verification
The interaction of interest is the lock engaging while a register write is already being requested. In mode 1101 the bench raises the pin and holds a plain write request for the following cycles. It expects the grant to stay 1 through the second clock edge, while the lock register has not yet changed, and to drop to 0 on the cycle in which `map_locked_o` rises. The bench then applies the exempt write kinds against the locked map to confirm that only those are accepted.

// File: rtl/gpin_pkg.sv
package gpin_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_FAULT = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_IPWR  = 4'b0011;
  localparam logic [MODE_W-1:0] MODE_VPWR  = 4'b0100;
  localparam logic [MODE_W-1:0] MODE_PROT  = 4'b0101;
  localparam logic [MODE_W-1:0] MODE_CLR   = 4'b0111;
  localparam logic [MODE_W-1:0] MODE_LOAD  = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_FGEN  = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_MARG  = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_RST   = 4'b1011;
  localparam logic [MODE_W-1:0] MODE_NVM   = 4'b1100;
  localparam logic [MODE_W-1:0] MODE_LOCK  = 4'b1101;

  typedef struct packed {
    logic rise;
    logic fall;
    logic lvl;
  } gpin_edge_t;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FAULT, MODE_IPWR, MODE_VPWR, MODE_PROT, MODE_CLR, MODE_LOAD,
      MODE_FGEN, MODE_MARG, MODE_RST, MODE_NVM, MODE_LOCK: mode_ok = 1'b1;
      default: mode_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpin_sync.sv
module gpin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_LVL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpin_edge.sv
module gpin_edge
  import gpin_pkg::*;
#(
  parameter logic RST_LVL = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  output gpin_edge_t        ev_o
);
  logic              prev_q;
  logic [MODE_W:0]   cfg_q;
  logic              cfg_chg;

  // a config change reloads the history and masks that cycle's edge
  assign cfg_chg = (cfg_q != {en_i, mode_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= RST_LVL;
      cfg_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      cfg_q  <= {en_i, mode_i};
    end
  end

  assign ev_o.rise = lvl_i & ~prev_q & ~cfg_chg;
  assign ev_o.fall = ~lvl_i & prev_q & ~cfg_chg;
  assign ev_o.lvl  = lvl_i;

  assert_rise_single_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o.rise |=> !ev_o.rise);
  assert_fall_single_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o.fall |=> !ev_o.fall);
endmodule

// File: rtl/gpin_decode.sv
module gpin_decode
  import gpin_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NCH-1:0]    ch_sel_i,
  input  logic [NCH-1:0]    sync_en_i,
  input  gpin_edge_t        ev_i,
  output logic              fault_o,
  output logic              prot_o,
  output logic              clr_o,
  output logic              rst_o,
  output logic              nvm_o,
  output logic              lock_o,
  output logic [NCH-1:0]    ipdn_o,
  output logic [NCH-1:0]    ipup_o,
  output logic [NCH-1:0]    vpdn_o,
  output logic [NCH-1:0]    vpup_o,
  output logic [NCH-1:0]    ldac_o,
  output logic [NCH-1:0]    fstop_o,
  output logic [NCH-1:0]    fstart_o,
  output logic [NCH-1:0]    mlo_o,
  output logic [NCH-1:0]    mhi_o
);
  localparam int NPULSE = 2 + 9 * NCH;

  logic              fault_d, prot_d, clr_d, rst_d, nvm_d, lock_d;
  logic              fault_q, prot_q, clr_q, rst_q, nvm_q, lock_q;
  logic [NCH-1:0]    ipdn_d, ipup_d, vpdn_d, vpup_d, ldac_d, fstop_d, fstart_d, mlo_d, mhi_d;
  logic [NCH-1:0]    ipdn_q, ipup_q, vpdn_q, vpup_q, ldac_q, fstop_q, fstart_q, mlo_q, mhi_q;
  logic [NCH-1:0]    fall_v, rise_v;
  logic [NPULSE-1:0] pulse_all;

  assign fall_v = {NCH{ev_i.fall}} & ch_sel_i;
  assign rise_v = {NCH{ev_i.rise}} & ch_sel_i;

  always_comb begin
    fault_d  = 1'b0;
    prot_d   = 1'b0;
    clr_d    = 1'b0;
    rst_d    = rst_q;
    nvm_d    = nvm_q;
    lock_d   = lock_q;
    ipdn_d   = '0;
    ipup_d   = '0;
    vpdn_d   = '0;
    vpup_d   = '0;
    ldac_d   = '0;
    fstop_d  = '0;
    fstart_d = '0;
    mlo_d    = '0;
    mhi_d    = '0;
    if (en_i) begin
      case (mode_i)
        MODE_FAULT: fault_d = ev_i.fall;
        MODE_IPWR: begin
          ipdn_d = fall_v;
          ipup_d = rise_v;
        end
        MODE_VPWR: begin
          vpdn_d = fall_v;
          vpup_d = rise_v;
        end
        MODE_PROT: prot_d = ev_i.fall;
        MODE_CLR:  clr_d  = ~ev_i.lvl;
        MODE_LOAD: ldac_d = fall_v & sync_en_i;
        MODE_FGEN: begin
          fstop_d  = fall_v;
          fstart_d = rise_v;
        end
        MODE_MARG: begin
          mlo_d = fall_v;
          mhi_d = rise_v;
        end
        MODE_RST: begin
          if (ev_i.fall)      rst_d = 1'b1;
          else if (ev_i.rise) rst_d = 1'b0;
        end
        MODE_NVM: begin
          if (ev_i.fall)      nvm_d = 1'b1;
          else if (ev_i.rise) nvm_d = 1'b0;
        end
        MODE_LOCK: begin
          if (ev_i.fall)      lock_d = 1'b0;
          else if (ev_i.rise) lock_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q  <= 1'b0;
      prot_q   <= 1'b0;
      clr_q    <= 1'b0;
      rst_q    <= 1'b0;
      nvm_q    <= 1'b0;
      lock_q   <= 1'b0;
      ipdn_q   <= '0;
      ipup_q   <= '0;
      vpdn_q   <= '0;
      vpup_q   <= '0;
      ldac_q   <= '0;
      fstop_q  <= '0;
      fstart_q <= '0;
      mlo_q    <= '0;
      mhi_q    <= '0;
    end else begin
      fault_q  <= fault_d;
      prot_q   <= prot_d;
      clr_q    <= clr_d;
      rst_q    <= rst_d;
      nvm_q    <= nvm_d;
      lock_q   <= lock_d;
      ipdn_q   <= ipdn_d;
      ipup_q   <= ipup_d;
      vpdn_q   <= vpdn_d;
      vpup_q   <= vpup_d;
      ldac_q   <= ldac_d;
      fstop_q  <= fstop_d;
      fstart_q <= fstart_d;
      mlo_q    <= mlo_d;
      mhi_q    <= mhi_d;
    end
  end

  assign pulse_all = {fault_q, prot_q, ipdn_q, ipup_q, vpdn_q, vpup_q,
                      ldac_q, fstop_q, fstart_q, mlo_q, mhi_q};

  assign fault_o  = fault_q;
  assign prot_o   = prot_q;
  assign clr_o    = clr_q;
  assign rst_o    = rst_q;
  assign nvm_o    = nvm_q;
  assign lock_o   = lock_q;
  assign ipdn_o   = ipdn_q;
  assign ipup_o   = ipup_q;
  assign vpdn_o   = vpdn_q;
  assign vpup_o   = vpup_q;
  assign ldac_o   = ldac_q;
  assign fstop_o  = fstop_q;
  assign fstart_o = fstart_q;
  assign mlo_o    = mlo_q;
  assign mhi_o    = mhi_q;

  assert_disabled_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pulse_all == '0) && !clr_q && $stable(rst_q) && $stable(nvm_q) && $stable(lock_q));
  assert_fault_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |=> !fault_q);
  assert_clr_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> ($past(mode_i) == MODE_CLR) && $past(en_i));
  assert_ldac_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldac_q & ~$past(ch_sel_i & sync_en_i)) == '0);
  assert_reset_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> ($past(mode_i) == MODE_RST));
  assert_invalid_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_ok(mode_i) |=> (pulse_all == '0) && !clr_q && $stable(rst_q) && $stable(nvm_q) && $stable(lock_q));
endmodule

// File: rtl/gpin_wr_guard.sv
module gpin_wr_guard (
  input  logic locked_i,
  input  logic req_i,
  input  logic unlock_fld_i,
  input  logic reset_fld_i,
  input  logic from_i2c_i,
  output logic grant_o
);
  logic exempt;

  assign exempt  = unlock_fld_i | (reset_fld_i & from_i2c_i);
  assign grant_o = req_i & (~locked_i | exempt);
endmodule

// File: rtl/gpin_event_dispatch.sv
module gpin_event_dispatch
  import gpin_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              in_en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NCH-1:0]    ch_sel_i,
  input  logic [NCH-1:0]    sync_en_i,
  input  logic              wr_req_i,
  input  logic              wr_unlock_fld_i,
  input  logic              wr_reset_fld_i,
  input  logic              wr_from_i2c_i,
  output logic              wr_grant_o,
  output logic              fault_dump_o,
  output logic              protect_o,
  output logic              clr_o,
  output logic              reset_o,
  output logic              nvm_wr_allow_o,
  output logic              map_locked_o,
  output logic [NCH-1:0]    iout_pdn_o,
  output logic [NCH-1:0]    iout_pup_o,
  output logic [NCH-1:0]    vout_pdn_o,
  output logic [NCH-1:0]    vout_pup_o,
  output logic [NCH-1:0]    ldac_o,
  output logic [NCH-1:0]    fgen_stop_o,
  output logic [NCH-1:0]    fgen_start_o,
  output logic [NCH-1:0]    margin_lo_o,
  output logic [NCH-1:0]    margin_hi_o
);
  localparam logic IDLE_LVL = 1'b1;

  logic       pin_s;
  gpin_edge_t ev;

  gpin_sync #(.STAGES(SYNC_STAGES), .RST_LVL(IDLE_LVL)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  gpin_edge #(.RST_LVL(IDLE_LVL)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_s),
    .en_i  (in_en_i),
    .mode_i(mode_i),
    .ev_o  (ev)
  );

  gpin_decode #(.NCH(NCH)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (in_en_i),
    .mode_i   (mode_i),
    .ch_sel_i (ch_sel_i),
    .sync_en_i(sync_en_i),
    .ev_i     (ev),
    .fault_o  (fault_dump_o),
    .prot_o   (protect_o),
    .clr_o    (clr_o),
    .rst_o    (reset_o),
    .nvm_o    (nvm_wr_allow_o),
    .lock_o   (map_locked_o),
    .ipdn_o   (iout_pdn_o),
    .ipup_o   (iout_pup_o),
    .vpdn_o   (vout_pdn_o),
    .vpup_o   (vout_pup_o),
    .ldac_o   (ldac_o),
    .fstop_o  (fgen_stop_o),
    .fstart_o (fgen_start_o),
    .mlo_o    (margin_lo_o),
    .mhi_o    (margin_hi_o)
  );

  gpin_wr_guard u_guard (
    .locked_i    (map_locked_o),
    .req_i       (wr_req_i),
    .unlock_fld_i(wr_unlock_fld_i),
    .reset_fld_i (wr_reset_fld_i),
    .from_i2c_i  (wr_from_i2c_i),
    .grant_o     (wr_grant_o)
  );

  assert_iout_selected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((iout_pdn_o | iout_pup_o) & ~$past(ch_sel_i)) == '0);
  assert_locked_refuse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_locked_o && wr_req_i && !wr_unlock_fld_i && !(wr_reset_fld_i && wr_from_i2c_i)) |-> !wr_grant_o);
  assert_unlocked_pass_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!map_locked_o && wr_req_i) |-> wr_grant_o);
endmodule

// File: tb/gpin_event_dispatch_tb.sv
module gpin_event_dispatch_tb;
  localparam int NCH = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pin_i = 1'b1;
  logic in_en_i = 1'b0;
  logic [3:0] mode_i = 4'b0000;
  logic [NCH-1:0] ch_sel_i = '0;
  logic [NCH-1:0] sync_en_i = '0;
  logic wr_req_i = 1'b0, wr_unlock_fld_i = 1'b0, wr_reset_fld_i = 1'b0, wr_from_i2c_i = 1'b0;
  logic wr_grant_o, fault_dump_o, protect_o, clr_o, reset_o, nvm_wr_allow_o, map_locked_o;
  logic [NCH-1:0] iout_pdn_o, iout_pup_o, vout_pdn_o, vout_pup_o, ldac_o;
  logic [NCH-1:0] fgen_stop_o, fgen_start_o, margin_lo_o, margin_hi_o;

  int checks = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  gpin_event_dispatch #(.NCH(NCH)) u_dut (.*);

  logic [2+9*NCH-1:0] pulses;
  assign pulses = {fault_dump_o, protect_o, iout_pdn_o, iout_pup_o, vout_pdn_o, vout_pup_o,
                   ldac_o, fgen_stop_o, fgen_start_o, margin_lo_o, margin_hi_o};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic en, input logic [3:0] m);
    @(negedge clk_i);
    in_en_i = en;
    mode_i  = m;
    repeat (2) @(negedge clk_i);
  endtask

  // returns at the sample point where outputs reflect the new pin level
  task automatic drive_pin(input logic v);
    @(negedge clk_i);
    pin_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic t_reset();
    chk("R13 reset pulses", 64'(pulses), 0);
    chk("R13 reset levels", {clr_o, reset_o, nvm_wr_allow_o, map_locked_o}, 0);
    wr_req_i = 1'b1;
    #1 chk("R12 unlocked grant", wr_grant_o, 1);
    wr_req_i = 1'b0;
  endtask

  task automatic t_disabled();
    set_mode(1'b0, 4'b1011);
    drive_pin(1'b0);
    chk("R1 reset held off", reset_o, 0);
    chk("R1 pulses off", 64'(pulses), 0);
    set_mode(1'b0, 4'b0111);
    chk("R1 clr off", clr_o, 0);
    set_mode(1'b0, 4'b0010);
    drive_pin(1'b1);
    drive_pin(1'b0);
    chk("R1 fault off", fault_dump_o, 0);
    drive_pin(1'b1);
  endtask

  task automatic t_fault();
    set_mode(1'b1, 4'b0010);
    drive_pin(1'b0);
    chk("R2 fall pulse", fault_dump_o, 1);
    chk("R14 only fault", 64'(pulses), 64'(1) << (1 + 9*NCH));
    @(negedge clk_i);
    chk("R14 one cycle", fault_dump_o, 0);
    drive_pin(1'b1);
    chk("R2 rise ignored", 64'(pulses), 0);
  endtask

  task automatic t_pair(input logic [3:0] m, input logic [NCH-1:0] sel, input string req, input int which);
    logic [NCH-1:0] a, b;
    set_mode(1'b1, m);
    ch_sel_i = sel;
    drive_pin(1'b0);
    case (which)
      0: begin a = iout_pdn_o;  b = iout_pup_o;   end
      1: begin a = vout_pdn_o;  b = vout_pup_o;   end
      2: begin a = fgen_stop_o; b = fgen_start_o; end
      default: begin a = margin_lo_o; b = margin_hi_o; end
    endcase
    chk({req, " fall"}, {a, b}, {sel, {NCH{1'b0}}});
    drive_pin(1'b1);
    case (which)
      0: begin a = iout_pdn_o;  b = iout_pup_o;   end
      1: begin a = vout_pdn_o;  b = vout_pup_o;   end
      2: begin a = fgen_stop_o; b = fgen_start_o; end
      default: begin a = margin_lo_o; b = margin_hi_o; end
    endcase
    chk({req, " rise"}, {a, b}, {{NCH{1'b0}}, sel});
    @(negedge clk_i);
    chk({req, " one cycle"}, 64'(pulses), 0);
  endtask

  task automatic t_protect();
    set_mode(1'b1, 4'b0101);
    drive_pin(1'b0);
    chk("R5 fall pulse", protect_o, 1);
    drive_pin(1'b1);
    chk("R5 rise ignored", protect_o, 0);
  endtask

  task automatic t_clr();
    set_mode(1'b1, 4'b0111);
    chk("R6 high released", clr_o, 0);
    drive_pin(1'b0);
    chk("R6 low asserted", clr_o, 1);
    repeat (5) @(negedge clk_i);
    chk("R6 still asserted", clr_o, 1);
    drive_pin(1'b1);
    chk("R6 released", clr_o, 0);
  endtask

  task automatic t_ldac();
    set_mode(1'b1, 4'b1000);
    ch_sel_i  = 4'b1110;
    sync_en_i = 4'b0111;
    drive_pin(1'b0);
    chk("R7 load gated", ldac_o, 4'b0110);
    drive_pin(1'b1);
    chk("R7 rise ignored", 64'(pulses), 0);
    sync_en_i = '0;
  endtask

  task automatic t_reset_mode();
    set_mode(1'b1, 4'b1011);
    drive_pin(1'b0);
    chk("R10 reset set", reset_o, 1);
    repeat (6) @(negedge clk_i);
    chk("R10 reset held", reset_o, 1);
    drive_pin(1'b1);
    chk("R10 reset released", reset_o, 0);
  endtask

  task automatic t_nvm();
    set_mode(1'b1, 4'b1100);
    drive_pin(1'b0);
    chk("R11 nvm allow", nvm_wr_allow_o, 1);
    drive_pin(1'b1);
    chk("R11 nvm block", nvm_wr_allow_o, 0);
  endtask

  task automatic t_lock();
    set_mode(1'b1, 4'b1101);
    drive_pin(1'b0);
    chk("R12 unlocked", map_locked_o, 0);
    // lock engages while a plain write is pending
    @(negedge clk_i);
    pin_i = 1'b1;
    wr_req_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R12 grant before lock", {map_locked_o, wr_grant_o}, 2'b01);
    @(negedge clk_i);
    chk("R12 refused when locked", {map_locked_o, wr_grant_o}, 2'b10);
    wr_unlock_fld_i = 1'b1;
    #1 chk("R12 unlock field passes", wr_grant_o, 1);
    wr_unlock_fld_i = 1'b0;
    wr_reset_fld_i = 1'b1;
    wr_from_i2c_i = 1'b0;
    #1 chk("R12 reset field over SPI refused", wr_grant_o, 0);
    wr_from_i2c_i = 1'b1;
    #1 chk("R12 reset field over I2C passes", wr_grant_o, 1);
    wr_reset_fld_i = 1'b0;
    wr_from_i2c_i = 1'b0;
    drive_pin(1'b0);
    chk("R12 unlocked again", {map_locked_o, wr_grant_o}, 2'b01);
    wr_req_i = 1'b0;
    drive_pin(1'b1);
    chk("R12 relocked", map_locked_o, 1);
    drive_pin(1'b0);
  endtask

  task automatic t_invalid();
    logic [3:0] bad [5] = '{4'b0000, 4'b0001, 4'b0110, 4'b1110, 4'b1111};
    ch_sel_i = '1;
    foreach (bad[i]) begin
      set_mode(1'b1, bad[i]);
      drive_pin(1'b1);
      chk("R13 invalid rise", {64'(pulses), 4'(0)} == 0 && {clr_o, reset_o, nvm_wr_allow_o, map_locked_o} == 0, 1);
      drive_pin(1'b0);
      chk("R13 invalid fall", {clr_o, reset_o, nvm_wr_allow_o, map_locked_o, 60'(pulses)}, 0);
    end
  endtask

  task automatic t_cfg_change();
    // pin is low here; switching into a falling-edge mode must not fire
    set_mode(1'b1, 4'b0010);
    repeat (3) @(negedge clk_i);
    chk("R14 mode switch no edge", fault_dump_o, 0);
    set_mode(1'b0, 4'b1011);
    set_mode(1'b1, 4'b1011);
    repeat (3) @(negedge clk_i);
    chk("R14 enable switch no edge", reset_o, 0);
    drive_pin(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_disabled();
    t_fault();
    t_pair(4'b0011, 4'b0101, "R3 iout", 0);
    t_pair(4'b0100, 4'b1010, "R4 vout", 1);
    t_protect();
    t_clr();
    t_ldac();
    t_pair(4'b1001, 4'b0011, "R8 fgen", 2);
    t_pair(4'b1010, 4'b1100, "R9 margin", 3);
    t_reset_mode();
    t_nvm();
    t_lock();
    t_invalid();
    t_cfg_change();
    summary();
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule